// File: doc/BRIEF.md
# Programmable Frequency Generator Bank

A bank of six clock dividers for one synchronous clock domain. Each channel picks one of three source clock-enable strobes: the processor clock, the auxiliary PLL or the second auxiliary PLL. It divides the strobe train by a programmed ratio and drives two outputs. The first is a divided square-wave level. The second is a one-cycle strobe at the start of every output period. Channels 0 to 2 are configured from control word 0 and channels 3 to 5 from control word 1. Both words are written through a single-cycle register port. A third address takes enable and disable commands for individual channels.

A parameter picks one of two field layouts. The legacy layout uses a one-bit source select, a separate enable bit and even ratios only. The extended layout uses a two-bit source code in which zero means off, and a scale bit in each control word that switches its channels to any integer ratio. In the extended layout the bank keeps the last nonzero source code of every channel, so that an enable command can bring back the source that a disable command removed.

Top module: `fgen_bank`

## Requirements
- R1: A write to address 0 or 1 stores all 32 bits, and a read of that address returns exactly the stored word. Reads of address 2 or 3 return zero.
- R2: Channel c is configured by the 10-bit field at bit 10*(c mod 3) of control word c/3. Inside the field, bits 9:2 hold the divisor code N.
- R3: Legacy layout: field bit 0 selects the source (0 processor clock, 1 auxiliary PLL), and the ratio is (N+1)*2. Bit 30 of the control word has no effect.
- R4: Legacy layout: field bit 1 enables the channel. A disabled channel holds its level output low and emits no strobes.
- R5: Extended layout: field bits 1:0 are the source code. Code 0 disables the channel, with the level output low and no strobes. Code 1 selects the second auxiliary PLL, code 2 the processor clock and code 3 the auxiliary PLL.
- R6: Extended layout: with bit 30 of a control word clear, the ratio of its channels is (N+1)*2. With bit 30 set, the ratio is N+1.
- R7: For a ratio R of 2 or more, each output period lasts R source ticks. The level output is high for the first floor(R/2) ticks. The strobe is high for one cycle in the cycle where the level output starts the period. For R = 1, both outputs repeat each source tick one cycle later.
- R8: A write to address 2 is a gate command: bits 5:0 enable channels and bits 21:16 disable them, and a disable bit wins over an enable bit for the same channel. In the legacy layout the command sets or clears field bit 1. In the extended layout a disable clears field bits 1:0 and keeps the other bits. An enable writes back the last nonzero source code written to that channel, which is 1 after reset.
- R9: A change of divisor or source on a running channel takes effect only at the next period boundary. The period in progress completes at its old length.
- R10: After reset both control words are zero, and every level output and strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_tick_i | input | 1 | Processor clock source strobe |
| aux_tick_i | input | 1 | Auxiliary PLL source strobe |
| aux2_tick_i | input | 1 | Second auxiliary PLL source strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address (0, 1 control words; 2 gate command) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| div_clk_o | output | 6 | Divided level output per channel |
| div_stb_o | output | 6 | Period-start strobe per channel |

## Verification
A wrong divisor decode or a miscounted counter changes the spacing between strobes, and the very next full period shows it. A wrong high-phase threshold changes the high count of the level output within that period. A stale active ratio or source appears as an extra period at the old length, visible one period after a live reprogramming. A shadow source that was lost or never updated shows up in the control word readback on the cycle after an enable command, and in the period measured right after it.

// File: rtl/fgen_pkg.sv
package fgen_pkg;
  localparam int unsigned FIELD_W    = 10;
  localparam int unsigned CH_PER_REG = 3;
  localparam int unsigned CODE_W     = 8;
  localparam int unsigned RATIO_W    = CODE_W + 2;
  localparam int unsigned SCALE_BIT  = 30;
  localparam int unsigned DIS_OFS    = 16;

  // internal source index
  typedef enum logic [1:0] {
    SRC_CPU  = 2'd0,
    SRC_AUX  = 2'd1,
    SRC_AUX2 = 2'd2
  } src_e;

  function automatic logic [RATIO_W-1:0] calc_ratio(input logic scale,
                                                    input logic [CODE_W-1:0] code);
    logic [RATIO_W-1:0] base;
    base = RATIO_W'(code) + RATIO_W'(1);
    return scale ? base : (base << 1);
  endfunction
endpackage

// File: rtl/fgen_regs.sv
module fgen_regs #(
  parameter bit          EXT    = 1'b1,
  parameter int unsigned NCH    = 6,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned NREG  = (NCH + fgen_pkg::CH_PER_REG - 1) / fgen_pkg::CH_PER_REG
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  output logic [NREG-1:0][31:0] ctl_o
);
  import fgen_pkg::*;

  logic [NREG-1:0][31:0] ctl_q;
  logic [NCH-1:0][1:0]   shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q    <= '0;
      shadow_q <= {NCH{2'd1}};
    end else if (we_i) begin
      for (int r = 0; r < int'(NREG); r++) begin
        if (int'(addr_i) == r) ctl_q[r] <= wdata_i;
      end
      for (int ch = 0; ch < int'(NCH); ch++) begin
        if (int'(addr_i) == ch / CH_PER_REG) begin
          if (wdata_i[(ch % CH_PER_REG) * FIELD_W +: 2] != 2'd0)
            shadow_q[ch] <= wdata_i[(ch % CH_PER_REG) * FIELD_W +: 2];
        end
        if (int'(addr_i) == int'(NREG)) begin
          if (wdata_i[DIS_OFS + ch]) begin
            if (EXT) ctl_q[ch / CH_PER_REG][(ch % CH_PER_REG) * FIELD_W +: 2] <= 2'd0;
            else     ctl_q[ch / CH_PER_REG][(ch % CH_PER_REG) * FIELD_W + 1] <= 1'b0;
          end else if (wdata_i[ch]) begin
            if (EXT) ctl_q[ch / CH_PER_REG][(ch % CH_PER_REG) * FIELD_W +: 2] <= shadow_q[ch];
            else     ctl_q[ch / CH_PER_REG][(ch % CH_PER_REG) * FIELD_W + 1] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < int'(NREG); r++) begin
      if (int'(addr_i) == r) rdata_o = ctl_q[r];
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/fgen_decode.sv
module fgen_decode #(
  parameter bit EXT = 1'b1
) (
  input  logic [fgen_pkg::FIELD_W-1:0] field_i,
  input  logic                         scale_i,
  output logic                         en_o,
  output logic [1:0]                   src_o,
  output logic                         scale_o,
  output logic [fgen_pkg::CODE_W-1:0]  code_o
);
  import fgen_pkg::*;

  assign code_o = field_i[FIELD_W-1:2];

  generate
    if (EXT) begin : g_ext
      assign en_o    = |field_i[1:0];
      assign scale_o = scale_i;
      always_comb begin
        unique case (field_i[1:0])
          2'd1:    src_o = SRC_AUX2;
          2'd3:    src_o = SRC_AUX;
          default: src_o = SRC_CPU;
        endcase
      end
    end else begin : g_leg
      assign en_o    = field_i[1];
      assign scale_o = 1'b0;
      assign src_o   = field_i[0] ? SRC_AUX : SRC_CPU;
    end
  endgenerate
endmodule

// File: rtl/fgen_chan.sv
module fgen_chan #(
  parameter int unsigned NSRC = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic [1:0]                    src_i,
  input  logic                          scale_i,
  input  logic [fgen_pkg::CODE_W-1:0]   code_i,
  input  logic [NSRC-1:0]               tick_i,
  output logic                          clk_o,
  output logic                          stb_o,
  output logic [fgen_pkg::RATIO_W-1:0]  ratio_o
);
  import fgen_pkg::*;

  logic [RATIO_W-1:0] ratio_cfg, ratio_q, ratio_n, cnt_q, cnt_n;
  logic [1:0]         src_q, src_n;
  logic               en_q, tick, start, wrap, clk_q, stb_q, clk_n, stb_n;

  assign ratio_cfg = calc_ratio(scale_i, code_i);
  assign tick      = (int'(src_q) < int'(NSRC)) ? tick_i[src_q] : 1'b0;
  assign start     = en_i & ~en_q;
  assign wrap      = tick & en_q & (cnt_q == ratio_q - RATIO_W'(1));

  always_comb begin
    cnt_n   = cnt_q;
    ratio_n = ratio_q;
    src_n   = src_q;
    if (!en_i || start || wrap) begin
      // period boundary (or idle): latch the configuration
      cnt_n   = '0;
      ratio_n = ratio_cfg;
      src_n   = src_i;
    end else if (tick) begin
      cnt_n = cnt_q + RATIO_W'(1);
    end
    stb_n = en_i & wrap;
    if (ratio_n == RATIO_W'(1)) clk_n = en_i & wrap;
    else                        clk_n = en_i & (cnt_n < (ratio_n >> 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      cnt_q   <= '0;
      ratio_q <= RATIO_W'(2);
      src_q   <= SRC_CPU;
      clk_q   <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      en_q    <= en_i;
      cnt_q   <= cnt_n;
      ratio_q <= ratio_n;
      src_q   <= src_n;
      clk_q   <= clk_n;
      stb_q   <= stb_n;
    end
  end

  assign clk_o   = clk_q;
  assign stb_o   = stb_q;
  assign ratio_o = ratio_q;
endmodule

// File: rtl/fgen_bank.sv
module fgen_bank #(
  parameter bit          EXT    = 1'b1,
  parameter int unsigned NCH    = 6,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_tick_i,
  input  logic              aux_tick_i,
  input  logic              aux2_tick_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [NCH-1:0]    div_clk_o,
  output logic [NCH-1:0]    div_stb_o
);
  import fgen_pkg::*;

  localparam int unsigned NREG = (NCH + CH_PER_REG - 1) / CH_PER_REG;
  localparam int unsigned NSRC = 3;

  logic [NREG-1:0][31:0]        ctl_q;
  logic [NSRC-1:0]              ticks;
  logic [NCH-1:0]               ch_en;
  logic [NCH-1:0][RATIO_W-1:0]  act_ratio;

  assign ticks = {aux2_tick_i, aux_tick_i, cpu_tick_i};

  fgen_regs #(.EXT(EXT), .NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .ctl_o   (ctl_q)
  );

  for (genvar c = 0; c < int'(NCH); c++) begin : g_ch
    localparam int unsigned RIDX = c / CH_PER_REG;
    localparam int unsigned OFS  = (c % CH_PER_REG) * FIELD_W;
    logic [1:0]        src;
    logic              scale;
    logic [CODE_W-1:0] code;

    fgen_decode #(.EXT(EXT)) u_dec (
      .field_i (ctl_q[RIDX][OFS +: FIELD_W]),
      .scale_i (ctl_q[RIDX][SCALE_BIT]),
      .en_o    (ch_en[c]),
      .src_o   (src),
      .scale_o (scale),
      .code_o  (code)
    );

    fgen_chan #(.NSRC(NSRC)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (ch_en[c]),
      .src_i   (src),
      .scale_i (scale),
      .code_i  (code),
      .tick_i  (ticks),
      .clk_o   (div_clk_o[c]),
      .stb_o   (div_stb_o[c]),
      .ratio_o (act_ratio[c])
    );
  end
endmodule

// File: rtl/fgen_bank_chk.sv
module fgen_bank_chk #(
  parameter bit          EXT    = 1'b1,
  parameter int unsigned NCH    = 6,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned NREG   = 2
) (
  input logic                                   clk_i,
  input logic                                   rst_ni,
  input logic                                   reg_we_i,
  input logic [ADDR_W-1:0]                      reg_addr_i,
  input logic [31:0]                            reg_wdata_i,
  input logic [31:0]                            reg_rdata_o,
  input logic [NCH-1:0]                         div_clk_o,
  input logic [NCH-1:0]                         div_stb_o,
  input logic [NCH-1:0]                         ch_en,
  input logic [NREG-1:0][31:0]                  ctl_q,
  input logic [NCH-1:0][fgen_pkg::RATIO_W-1:0]  act_ratio
);
  import fgen_pkg::*;

  p_rdback_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && int'(reg_addr_i) < int'(NREG)) |=>
      ((reg_addr_i != $past(reg_addr_i)) || (reg_rdata_o == $past(reg_wdata_i))));

  for (genvar c = 0; c < int'(NCH); c++) begin : g_c
    localparam int unsigned RIDX = c / CH_PER_REG;
    localparam int unsigned OFS  = (c % CH_PER_REG) * FIELD_W;

    // R4 / R5: off channel is quiet
    p_off_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_en[c] |=> (!div_clk_o[c] && !div_stb_o[c]));

    p_no_double_stb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_stb_o[c] && act_ratio[c] != RATIO_W'(1)) |=> !div_stb_o[c]);

    if (EXT) begin : g_e
      p_gate_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && int'(reg_addr_i) == int'(NREG) && reg_wdata_i[DIS_OFS + c]) |=>
          (ctl_q[RIDX][OFS +: 2] == 2'd0));
    end else begin : g_l
      p_gate_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && int'(reg_addr_i) == int'(NREG) && reg_wdata_i[DIS_OFS + c]) |=>
          !ctl_q[RIDX][OFS + 1]);
    end
  end
endmodule

bind fgen_bank fgen_bank_chk #(.EXT(EXT), .NCH(NCH), .ADDR_W(ADDR_W), .NREG(NREG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .div_clk_o   (div_clk_o),
  .div_stb_o   (div_stb_o),
  .ch_en       (ch_en),
  .ctl_q       (ctl_q),
  .act_ratio   (act_ratio)
);

// File: tb/fgen_bank_bench.sv
module fgen_bank_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_t = 1'b0, aux_t = 1'b0, aux2_t = 1'b0;
  logic        we_e = 1'b0, we_l = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_e, rd_l;
  logic [5:0]  dclk_e, dstb_e, dclk_l, dstb_l;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fgen_bank #(.EXT(1'b1)) u_fgen_bank (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_tick_i(cpu_t), .aux_tick_i(aux_t),
    .aux2_tick_i(aux2_t), .reg_we_i(we_e), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rd_e), .div_clk_o(dclk_e), .div_stb_o(dstb_e));

  fgen_bank #(.EXT(1'b0)) u_fgen_bank_leg (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_tick_i(cpu_t), .aux_tick_i(aux_t),
    .aux2_tick_i(aux2_t), .reg_we_i(we_l), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rd_l), .div_clk_o(dclk_l), .div_stb_o(dstb_l));

  // source strobes: cpu every cycle, aux every 2nd, aux2 every 3rd
  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      cpu_t  = 1'b1;
      aux_t  = (tc % 2) == 0;
      aux2_t = (tc % 3) == 0;
      tc++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit ext, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (ext) we_e = 1'b1; else we_l = 1'b1;
    @(negedge clk);
    we_e = 1'b0; we_l = 1'b0;
  endtask

  task automatic rd(input bit ext, input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = ext ? rd_e : rd_l;
  endtask

  function automatic bit stb_of(input bit ext, input int ch);
    return ext ? dstb_e[ch] : dstb_l[ch];
  endfunction

  function automatic bit lvl_of(input bit ext, input int ch);
    return ext ? dclk_e[ch] : dclk_l[ch];
  endfunction

  // waits for a strobe, then measures one full period and its high time
  task automatic measure(input bit ext, input int ch, output int per, output int hi);
    int w = 0;
    per = -1; hi = -1;
    do begin
      @(posedge clk); #1; w++;
    end while (!stb_of(ext, ch) && w < 6000);
    if (!stb_of(ext, ch)) return;
    per = 0; hi = 0;
    do begin
      per++;
      hi += int'(lvl_of(ext, ch));
      @(posedge clk); #1;
    end while (!stb_of(ext, ch) && per < 6000);
  endtask

  task automatic quiet(input bit ext, input int ch, input string req);
    int act = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      act += int'(lvl_of(ext, ch)) + int'(stb_of(ext, ch));
    end
    chk(act == 0, req, act, 0);
  endtask

  initial begin
    logic [31:0] v;
    int per, hi, k, r, ex_per, ex_hi, cnt;
    #20000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int per, hi, k, r, ex_per, ex_hi, cnt;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(posedge clk); #1;

    // R10: reset state
    chk(dclk_e == 0 && dstb_e == 0 && dclk_l == 0 && dstb_l == 0, "R10 outputs",
        int'({dclk_e, dstb_e}), 0);
    rd(1, 0, v); chk(v == 0, "R10 reg0", int'(v), 0);
    rd(1, 1, v); chk(v == 0, "R10 reg1", int'(v), 0);
    rd(0, 1, v); chk(v == 0, "R10 leg reg1", int'(v), 0);

    // R8: shadow source after reset is code 1
    wr(1, 2, 32'h0000_0020);
    rd(1, 1, v); chk(v == (32'd1 << 20), "R8 reset shadow", int'(v), 1 << 20);
    wr(1, 1, 32'h0);

    // R1: readback
    wr(1, 0, 32'hC5A3_0000);
    rd(1, 0, v); chk(v == 32'hC5A3_0000, "R1 readback", int'(v), int'(32'hC5A3_0000));
    wr(0, 1, 32'h8000_0000);
    rd(0, 1, v); chk(v == 32'h8000_0000, "R1 leg readback", int'(v), int'(32'h8000_0000));
    rd(1, 2, v); chk(v == 0, "R1 addr2 read", int'(v), 0);
    rd(1, 3, v); chk(v == 0, "R1 addr3 read", int'(v), 0);
    wr(1, 0, 32'h0); wr(0, 1, 32'h0);

    // R2 R3 R7: legacy sweep
    for (int ch = 0; ch < 6; ch++) begin
      for (int s = 0; s < 2; s++) begin
        for (int ni = 0; ni < 4; ni++) begin
          int n = (ni == 3) ? 5 : ni;
          k = s ? 2 : 1;
          v = (32'(n) << 2) | 32'h2 | 32'(s);
          v = v << (10 * (ch % 3));
          if (ni == 2) v |= 32'h4000_0000; // scale bit ignored in legacy
          wr(0, 2'(ch / 3), v);
          measure(0, ch, per, hi);
          chk(per == (n + 1) * 2 * k, "R3 legacy period", per, (n + 1) * 2 * k);
          chk(hi == (n + 1) * k, "R7 legacy high", hi, (n + 1) * k);
        end
      end
      wr(0, 2'(ch / 3), 32'h0);
    end
    wr(0, 0, (32'd255 << 2) | 32'h2);
    measure(0, 0, per, hi);
    chk(per == 512, "R3 legacy max ratio", per, 512);

    // R4: legacy enable bit clear
    wr(0, 0, (32'd1 << 2) | 32'h1);
    quiet(0, 0, "R4 legacy disabled");

    // R8 legacy gate
    wr(0, 1, (32'd1 << 12) | (32'd1 << 10));
    wr(0, 2, 32'h10);
    rd(0, 1, v); chk(v == ((32'd1 << 12) | (32'd3 << 10)), "R8 legacy enable", int'(v), 0);
    measure(0, 4, per, hi); chk(per == 8, "R8 legacy run", per, 8);
    wr(0, 2, 32'h0010_0010);
    rd(0, 1, v); chk(v == ((32'd1 << 12) | (32'd1 << 10)), "R8 legacy disable wins", int'(v), 0);
    quiet(0, 4, "R8 legacy quiet");
    wr(0, 1, 32'h0);

    // R2 R5 R6 R7: extended sweep
    for (int ch = 0; ch < 6; ch++) begin
      for (int code = 1; code < 4; code++) begin
        for (int sc = 0; sc < 2; sc++) begin
          for (int ni = 0; ni < 4; ni++) begin
            int n = (ni == 3) ? 4 : ni;
            k = (code == 1) ? 3 : (code == 2) ? 1 : 2;
            r = sc ? n + 1 : (n + 1) * 2;
            ex_per = r * k;
            ex_hi  = (r == 1) ? 1 : (r / 2) * k;
            v = ((32'(n) << 2) | 32'(code)) << (10 * (ch % 3));
            if (sc) v |= 32'h4000_0000;
            wr(1, 2'(ch / 3), v);
            measure(1, ch, per, hi);
            chk(per == ex_per, sc ? "R6 ext period scaled" : "R5 ext period", per, ex_per);
            chk(hi == ex_hi, "R7 ext high", hi, ex_hi);
          end
        end
      end
      wr(1, 2'(ch / 3), 32'h0);
    end

    // R5: code 0 off
    wr(1, 1, (32'd3 << 12) | 32'h4000_0000);
    quiet(1, 4, "R5 code0 disabled");

    // R8: extended gate and shadow restore
    wr(1, 0, (32'd1 << 12) | (32'd3 << 10));
    wr(1, 2, 32'h0002_0000);
    rd(1, 0, v); chk(v == (32'd1 << 12), "R8 ext disable", int'(v), 1 << 12);
    quiet(1, 1, "R8 ext quiet");
    wr(1, 2, 32'h0000_0002);
    rd(1, 0, v); chk(v == ((32'd1 << 12) | (32'd3 << 10)), "R8 ext restore", int'(v), 0);
    measure(1, 1, per, hi); chk(per == 8, "R8 ext restored period", per, 8);
    wr(1, 0, 32'h0);

    // R9: live change waits for the boundary
    wr(1, 0, 32'h4000_0000 | (32'd9 << 2) | 32'd2);
    measure(1, 0, per, hi); chk(per == 10, "R9 initial period", per, 10);
    cnt = 0;
    do begin @(posedge clk); #1; end while (!dstb_e[0]);
    addr = 0; wdata = 32'h4000_0000 | (32'd1 << 2) | 32'd2; we_e = 1'b1;
    do begin
      @(posedge clk); #1;
      we_e = 1'b0;
      cnt++;
    end while (!dstb_e[0] && cnt < 100);
    chk(cnt == 10, "R9 old period completes", cnt, 10);
    measure(1, 0, per, hi); chk(per == 2, "R9 new period", per, 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule